// File: doc/BRIEF.md
# Segmented Memory Access Sequencer

This block sits between the control path of a small 8-bit processor and its byte-wide memory bus. It keeps the four segment registers (code, data, extra, stack) together with the stack pointer and the instruction pointer. Each request names an access class. From that class and an extra-segment override bit, the block forms a 16-bit physical address with the segment byte above the offset byte, and then places one or two transfers on the bus.

Single-transfer requests are: instruction fetch, data load, data store, push and pop. Three requests take two transfers, issued in a fixed order on consecutive cycles. The first is an extended push of a segment register followed by a general byte. The second is an extended pop, which reverses that order. The third is a far jump that reads a new code segment and instruction pointer from two consecutive bytes. A register-set request loads any of the six registers directly, with no bus traffic. A request that would need a second, separate memory reference is refused. A request is taken only while the block is idle. The control path then sees a completion pulse in the cycle after the last transfer.

Top module: `seg_mem_seq`

## Requirements
- R1: After synchronous reset, all four segment registers, SP and IP are zero. busy, mem_req, rsp_valid and rsp_illegal are low.
- R2: A fetch (op 0) reads address {CS, IP}, ignores the extra-segment bit, increments IP modulo 256 and returns the byte in rsp_data. CS is used by no other request.
- R3: A load (op 1) reads and a store (op 2) writes address {DS, offset}, or {ES, offset} when req_xseg is 1. A load returns the byte read.
- R4: A push (op 3) first decrements SP modulo 256, then writes req_wdata at {SS, new SP}, or at {ES, new SP} when req_xseg is 1.
- R5: A pop (op 4) reads at {SS or ES, SP}, returns the byte, and then increments SP modulo 256.
- R6: An extended push (op 5) writes the segment register selected by req_reg (0 CS, 1 DS, 2 ES, 3 SS) at SP-1, then writes req_wdata at SP-2, in that order on consecutive cycles. It leaves SP lowered by 2.
- R7: An extended pop (op 6) reads at SP and returns that byte, then reads at SP+1 and loads that byte into the segment register selected by req_reg. It leaves SP raised by 2.
- R8: A far jump (op 7) reads {DS or ES, offset}, which loads CS, then reads {same segment, offset+1 modulo 256}, which loads IP.
- R9: A request with req_mem_operand set on any bus op, or with an op code above 8, is refused. rsp_illegal pulses in the next cycle, no transfer occurs and no register changes.
- R10: busy is high from the cycle after acceptance until the last transfer's cycle. Requests presented while busy are ignored.
- R11: A register-set request (op 8) loads req_wdata into the register named by req_reg (0 CS, 1 DS, 2 ES, 3 SS, 4 SP, 5 IP) with no bus transfer and no response.
- R12: Each transfer holds mem_req high for exactly one cycle. rsp_valid pulses in the cycle after the last transfer. rsp_data is zero on completion of writes and far jumps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when busy is low |
| req_op | input | 4 | Request code (0 fetch, 1 load, 2 store, 3 push, 4 pop, 5 extended push, 6 extended pop, 7 far jump, 8 register set) |
| req_reg | input | 3 | Segment or register selector |
| req_xseg | input | 1 | Extra-segment override |
| req_mem_operand | input | 1 | Operand is itself a memory reference |
| req_offset | input | 8 | Offset for load, store and far jump |
| req_wdata | input | 8 | Byte to write or register value to set |
| busy | output | 1 | Sequence in progress |
| rsp_valid | output | 1 | Completion pulse |
| rsp_illegal | output | 1 | Refusal pulse |
| rsp_data | output | 8 | Returned byte |
| mem_req | output | 1 | Bus transfer this cycle |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 16 | Physical address {segment, offset} |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid in the transfer cycle |

## Verification
The properties assume that memory answers a read in the same cycle mem_req is high. They also assume that reset is held from time zero, so the registers the history checks compare against start from a known value. The stimulus waits for busy to be low before presenting each request. The one deliberate exception is the pair of requests that tests R10: those are presented while busy is high and must not reach the bus. Every segment value the stimulus loads stays below 16, so the bench memory, which decodes only the low 12 address bits, never aliases two addresses.

// File: rtl/seg_mem_pkg.sv
package seg_mem_pkg;

  localparam int SEG_CNT   = 4;
  localparam int SEG_SEL_W = $clog2(SEG_CNT);
  localparam int OP_W      = 4;
  localparam int REG_W     = 3;

  typedef enum logic [OP_W-1:0] {
    OP_FETCH  = 4'd0,
    OP_LOAD   = 4'd1,
    OP_STORE  = 4'd2,
    OP_PUSH   = 4'd3,
    OP_POP    = 4'd4,
    OP_XPUSH  = 4'd5,
    OP_XPOP   = 4'd6,
    OP_FARJMP = 4'd7,
    OP_SETREG = 4'd8
  } op_e;

  // segment slots inside the bank; register-set selector adds SP and IP
  localparam logic [REG_W-1:0] RG_CS = 3'd0;
  localparam logic [REG_W-1:0] RG_DS = 3'd1;
  localparam logic [REG_W-1:0] RG_ES = 3'd2;
  localparam logic [REG_W-1:0] RG_SS = 3'd3;
  localparam logic [REG_W-1:0] RG_SP = 3'd4;
  localparam logic [REG_W-1:0] RG_IP = 3'd5;

  typedef enum logic [1:0] {
    CLS_CODE  = 2'd0,
    CLS_DATA  = 2'd1,
    CLS_STACK = 2'd2
  } acc_cls_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_T1   = 2'd1,
    ST_T2   = 2'd2
  } seq_st_e;

  function automatic acc_cls_e op_class(input logic [OP_W-1:0] op);
    case (op)
      OP_FETCH:                          return CLS_CODE;
      OP_PUSH, OP_POP, OP_XPUSH, OP_XPOP: return CLS_STACK;
      default:                           return CLS_DATA;
    endcase
  endfunction

  function automatic logic op_two_step(input logic [OP_W-1:0] op);
    return (op == OP_XPUSH) || (op == OP_XPOP) || (op == OP_FARJMP);
  endfunction

endpackage

// File: rtl/seg_bank.sv
module seg_bank
  import seg_mem_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [SEG_SEL_W-1:0] wsel,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [SEG_SEL_W-1:0] rsel,
  input  logic [1:0]           cls,
  input  logic                 xseg,
  output logic [DATA_W-1:0]    rdata,
  output logic [DATA_W-1:0]    cls_seg,
  output logic [DATA_W-1:0]    code_seg
);

  logic [DATA_W-1:0] seg_q [SEG_CNT];

  for (genvar g = 0; g < SEG_CNT; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst)
        seg_q[g] <= '0;
      else if (we && (wsel == SEG_SEL_W'(g)))
        seg_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata    = seg_q[rsel];
    code_seg = seg_q[RG_CS[SEG_SEL_W-1:0]];
    case (cls)
      CLS_CODE:  cls_seg = seg_q[RG_CS[SEG_SEL_W-1:0]];
      CLS_STACK: cls_seg = xseg ? seg_q[RG_ES[SEG_SEL_W-1:0]] : seg_q[RG_SS[SEG_SEL_W-1:0]];
      default:   cls_seg = xseg ? seg_q[RG_ES[SEG_SEL_W-1:0]] : seg_q[RG_DS[SEG_SEL_W-1:0]];
    endcase
  end

endmodule

// File: rtl/ptr_regs.sv
module ptr_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sp_we,
  input  logic [DATA_W-1:0] sp_d,
  input  logic              ip_we,
  input  logic [DATA_W-1:0] ip_d,
  output logic [DATA_W-1:0] sp_q,
  output logic [DATA_W-1:0] ip_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= '0;
      ip_q <= '0;
    end else begin
      if (sp_we) sp_q <= sp_d;
      if (ip_we) ip_q <= ip_d;
    end
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seg_mem_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [OP_W-1:0]      req_op,
  input  logic [REG_W-1:0]     req_reg,
  input  logic                 req_xseg,
  input  logic                 req_mem_operand,
  input  logic [DATA_W-1:0]    req_offset,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic [1:0]           cls,
  input  logic [DATA_W-1:0]    cls_seg,
  output logic [SEG_SEL_W-1:0] seg_rsel,
  input  logic [DATA_W-1:0]    seg_rd,
  output logic                 seg_we,
  output logic [SEG_SEL_W-1:0] seg_wsel,
  output logic [DATA_W-1:0]    seg_wdata,
  input  logic [DATA_W-1:0]    sp_q,
  input  logic [DATA_W-1:0]    ip_q,
  output logic                 sp_we,
  output logic [DATA_W-1:0]    sp_d,
  output logic                 ip_we,
  output logic [DATA_W-1:0]    ip_d,
  output logic                 busy,
  output logic                 rsp_valid,
  output logic                 rsp_illegal,
  output logic [DATA_W-1:0]    rsp_data,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata
);

  seq_st_e               state;
  logic [OP_W-1:0]       kind_q;
  logic [SEG_SEL_W-1:0]  pend_sel_q;
  logic [ADDR_W-1:0]     addr2_q;
  logic                  we2_q;
  logic [DATA_W-1:0]     wdata2_q;
  logic [DATA_W-1:0]     hold_q;

  logic                  accept;
  logic                  illegal;
  logic [DATA_W-1:0]     off1, off2;
  logic                  we1;
  logic [DATA_W-1:0]     wdata1;

  assign busy    = (state != ST_IDLE);
  assign accept  = req_valid && (state == ST_IDLE);
  assign illegal = (req_op > OP_SETREG) || (req_mem_operand && (req_op != OP_SETREG));
  assign cls     = op_class(req_op);
  assign seg_rsel = req_reg[SEG_SEL_W-1:0];

  // first/second transfer offsets, computed at acceptance
  always_comb begin
    off1   = req_offset;
    off2   = req_offset + 1'b1;
    we1    = 1'b0;
    wdata1 = req_wdata;
    case (req_op)
      OP_FETCH: off1 = ip_q;
      OP_STORE: we1  = 1'b1;
      OP_PUSH: begin
        off1 = sp_q - 1'b1;
        we1  = 1'b1;
      end
      OP_POP:  off1 = sp_q;
      OP_XPUSH: begin
        off1   = sp_q - 1'b1;
        off2   = sp_q - DATA_W'(2);
        we1    = 1'b1;
        wdata1 = seg_rd;
      end
      OP_XPOP: begin
        off1 = sp_q;
        off2 = sp_q + 1'b1;
      end
      default: ;
    endcase
  end

  // register updates: on acceptance, or on read completion of a sequence
  always_comb begin
    seg_we    = 1'b0;
    seg_wsel  = req_reg[SEG_SEL_W-1:0];
    seg_wdata = req_wdata;
    sp_we     = 1'b0;
    sp_d      = sp_q;
    ip_we     = 1'b0;
    ip_d      = ip_q;
    if (accept && !illegal) begin
      case (req_op)
        OP_SETREG: begin
          if (req_reg < RG_SP) seg_we = 1'b1;
          if (req_reg == RG_SP) begin sp_we = 1'b1; sp_d = req_wdata; end
          if (req_reg == RG_IP) begin ip_we = 1'b1; ip_d = req_wdata; end
        end
        OP_FETCH: begin ip_we = 1'b1; ip_d = ip_q + 1'b1; end
        OP_PUSH:  begin sp_we = 1'b1; sp_d = sp_q - 1'b1; end
        OP_POP:   begin sp_we = 1'b1; sp_d = sp_q + 1'b1; end
        OP_XPUSH: begin sp_we = 1'b1; sp_d = sp_q - DATA_W'(2); end
        OP_XPOP:  begin sp_we = 1'b1; sp_d = sp_q + DATA_W'(2); end
        default: ;
      endcase
    end else if (state == ST_T1 && kind_q == OP_FARJMP) begin
      seg_we    = 1'b1;
      seg_wsel  = RG_CS[SEG_SEL_W-1:0];
      seg_wdata = mem_rdata;
    end else if (state == ST_T2 && kind_q == OP_XPOP) begin
      seg_we    = 1'b1;
      seg_wsel  = pend_sel_q;
      seg_wdata = mem_rdata;
    end else if (state == ST_T2 && kind_q == OP_FARJMP) begin
      ip_we = 1'b1;
      ip_d  = mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      kind_q      <= '0;
      pend_sel_q  <= '0;
      addr2_q     <= '0;
      we2_q       <= 1'b0;
      wdata2_q    <= '0;
      hold_q      <= '0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      rsp_valid   <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_data    <= '0;
    end else begin
      rsp_valid   <= 1'b0;
      rsp_illegal <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (illegal) begin
              rsp_illegal <= 1'b1;
            end else if (req_op != OP_SETREG) begin
              mem_req    <= 1'b1;
              mem_we     <= we1;
              mem_addr   <= {cls_seg, off1};
              mem_wdata  <= wdata1;
              addr2_q    <= {cls_seg, off2};
              we2_q      <= (req_op == OP_XPUSH);
              wdata2_q   <= req_wdata;
              kind_q     <= req_op;
              pend_sel_q <= req_reg[SEG_SEL_W-1:0];
              state      <= ST_T1;
            end
          end
        end
        ST_T1: begin
          if (op_two_step(kind_q)) begin
            hold_q    <= mem_rdata;
            mem_addr  <= addr2_q;
            mem_we    <= we2_q;
            mem_wdata <= wdata2_q;
            state     <= ST_T2;
          end else begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_data  <= mem_we ? '0 : mem_rdata;
            state     <= ST_IDLE;
          end
        end
        default: begin
          mem_req   <= 1'b0;
          mem_we    <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_data  <= (kind_q == OP_XPOP) ? hold_q : '0;
          state     <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/seg_mem_seq.sv
module seg_mem_seq
  import seg_mem_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [2:0]        req_reg,
  input  logic              req_xseg,
  input  logic              req_mem_operand,
  input  logic [DATA_W-1:0] req_offset,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_illegal,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic [1:0]           cls;
  logic [DATA_W-1:0]    cls_seg;
  logic [DATA_W-1:0]    code_seg;
  logic [SEG_SEL_W-1:0] seg_rsel;
  logic [DATA_W-1:0]    seg_rd;
  logic                 seg_we;
  logic [SEG_SEL_W-1:0] seg_wsel;
  logic [DATA_W-1:0]    seg_wdata;
  logic [DATA_W-1:0]    sp_q, ip_q;
  logic                 sp_we, ip_we;
  logic [DATA_W-1:0]    sp_d, ip_d;

  seg_bank #(.DATA_W(DATA_W)) bank_i (
    .clk(clk), .rst(rst),
    .we(seg_we), .wsel(seg_wsel), .wdata(seg_wdata),
    .rsel(seg_rsel), .cls(cls), .xseg(req_xseg),
    .rdata(seg_rd), .cls_seg(cls_seg), .code_seg(code_seg)
  );

  ptr_regs #(.DATA_W(DATA_W)) ptr_i (
    .clk(clk), .rst(rst),
    .sp_we(sp_we), .sp_d(sp_d), .ip_we(ip_we), .ip_d(ip_d),
    .sp_q(sp_q), .ip_q(ip_q)
  );

  seq_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_op(req_op), .req_reg(req_reg),
    .req_xseg(req_xseg), .req_mem_operand(req_mem_operand),
    .req_offset(req_offset), .req_wdata(req_wdata),
    .cls(cls), .cls_seg(cls_seg), .seg_rsel(seg_rsel), .seg_rd(seg_rd),
    .seg_we(seg_we), .seg_wsel(seg_wsel), .seg_wdata(seg_wdata),
    .sp_q(sp_q), .ip_q(ip_q), .sp_we(sp_we), .sp_d(sp_d),
    .ip_we(ip_we), .ip_d(ip_d),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_illegal(rsp_illegal),
    .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

endmodule

// File: rtl/seg_mem_seq_chk.sv
module seg_mem_seq_chk #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [3:0]        req_op,
  input logic              req_mem_operand,
  input logic              busy,
  input logic              rsp_valid,
  input logic              rsp_illegal,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] code_seg,
  input logic [DATA_W-1:0] sp_q,
  input logic [DATA_W-1:0] ip_q
);

  logic take;
  assign take = req_valid && !busy && !req_mem_operand;

  p_fetch_cs_r2: assert property (@(posedge clk) disable iff (rst)
    (take && req_op == 4'd0) |=> (mem_req && !mem_we &&
      mem_addr == {$past(code_seg), $past(ip_q)}));

  p_push_predec_r4: assert property (@(posedge clk) disable iff (rst)
    (take && req_op == 4'd3) |=> (mem_req && mem_we &&
      mem_addr[DATA_W-1:0] == $past(sp_q) - 1'b1 && sp_q == $past(sp_q) - 1'b1));

  p_xpush_desc_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && $past(mem_req) && $past(mem_we)) |->
      (mem_addr[DATA_W-1:0] == $past(mem_addr[DATA_W-1:0]) - 1'b1 &&
       mem_addr[ADDR_W-1:DATA_W] == $past(mem_addr[ADDR_W-1:DATA_W])));

  p_pair_asc_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && $past(mem_req) && !$past(mem_we)) |->
      (mem_addr[DATA_W-1:0] == $past(mem_addr[DATA_W-1:0]) + 1'b1 &&
       mem_addr[ADDR_W-1:DATA_W] == $past(mem_addr[ADDR_W-1:DATA_W])));

  p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_illegal |-> (!mem_req && !busy && !rsp_valid));

  p_req_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  p_done_idle_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (!busy && !mem_req));

endmodule

bind seg_mem_seq seg_mem_seq_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
  .req_mem_operand(req_mem_operand), .busy(busy), .rsp_valid(rsp_valid),
  .rsp_illegal(rsp_illegal), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .code_seg(code_seg), .sp_q(sp_q), .ip_q(ip_q)
);

// File: tb/seg_mem_seq_tb_top.sv
module seg_mem_seq_tb_top;

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [7:0]  data;
  } bus_item_t;

  typedef struct packed {
    logic       ill;
    logic [7:0] data;
  } rsp_item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [3:0] req_op = '0;
  logic [2:0] req_reg = '0;
  logic       req_xseg = 1'b0;
  logic       req_mem_operand = 1'b0;
  logic [7:0] req_offset = '0;
  logic [7:0] req_wdata = '0;
  logic       busy, rsp_valid, rsp_illegal, mem_req, mem_we;
  logic [7:0] rsp_data, mem_wdata, mem_rdata;
  logic [15:0] mem_addr;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  bus_item_t exp_bus_q[$];
  string     bus_tag_q[$];
  rsp_item_t exp_rsp_q[$];
  string     rsp_tag_q[$];

  logic [7:0] mem     [4096];
  logic [7:0] ref_mem [4096];
  logic [7:0] m_seg [4];
  logic [7:0] m_sp, m_ip;

  always #2.5 clk = ~clk;

  seg_mem_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_reg(req_reg), .req_xseg(req_xseg), .req_mem_operand(req_mem_operand),
    .req_offset(req_offset), .req_wdata(req_wdata), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_illegal(rsp_illegal), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model: combinational read, write on the clock edge
  assign mem_rdata = mem[mem_addr[11:0]];
  always @(posedge clk) if (!rst && mem_req && mem_we) mem[mem_addr[11:0]] <= mem_wdata;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (mem_req) begin
        if (exp_bus_q.size() == 0) begin
          chk(0, "R10", "unexpected transfer addr", {16'h0, mem_addr}, 32'h0);
        end else begin
          bus_item_t e;
          string t;
          e = exp_bus_q.pop_front();
          t = bus_tag_q.pop_front();
          chk(mem_we == e.we, t, "transfer direction", {31'h0, mem_we}, {31'h0, e.we});
          chk(mem_addr == e.addr, t, "transfer address", {16'h0, mem_addr}, {16'h0, e.addr});
          if (e.we) chk(mem_wdata == e.data, t, "write byte", {24'h0, mem_wdata}, {24'h0, e.data});
        end
      end
      if (rsp_valid || rsp_illegal) begin
        if (exp_rsp_q.size() == 0) begin
          chk(0, "R12", "unexpected response", {31'h0, rsp_illegal}, 32'h0);
        end else begin
          rsp_item_t r;
          string t;
          r = exp_rsp_q.pop_front();
          t = rsp_tag_q.pop_front();
          chk(rsp_illegal == r.ill && rsp_valid == !r.ill, t, "response kind",
              {31'h0, rsp_illegal}, {31'h0, r.ill});
          if (!r.ill) chk(rsp_data == r.data, t, "response byte", {24'h0, rsp_data}, {24'h0, r.data});
        end
      end
    end
  end

  task automatic exp_bus(input logic we, input logic [15:0] a, input logic [7:0] d, input string t);
    bus_item_t b;
    b.we = we; b.addr = a; b.data = d;
    exp_bus_q.push_back(b);
    bus_tag_q.push_back(t);
    if (we) ref_mem[a[11:0]] = d;
  endtask

  task automatic exp_rsp(input logic ill, input logic [7:0] d, input string t);
    rsp_item_t r;
    r.ill = ill; r.data = d;
    exp_rsp_q.push_back(r);
    rsp_tag_q.push_back(t);
  endtask

  // driver: builds expectations from the requirements, then presents the request
  task automatic run(input logic [3:0] op, input logic [2:0] rg, input logic xs,
                     input logic mo, input logic [7:0] off, input logic [7:0] wd,
                     input string t);
    logic [7:0] s, o1, o2, d1, d2;
    logic [15:0] a1, a2;
    bit bad;
    bad = ((op != 4'd8) && mo) || (op > 4'd8);
    s = (op >= 4'd3 && op <= 4'd6) ? (xs ? m_seg[2] : m_seg[3]) : (xs ? m_seg[2] : m_seg[1]);
    if (bad) begin
      exp_rsp(1'b1, 8'h0, t);
    end else begin
      case (op)
        4'd0: begin
          a1 = {m_seg[0], m_ip};
          exp_bus(1'b0, a1, 8'h0, t); exp_rsp(1'b0, ref_mem[a1[11:0]], t);
          m_ip = m_ip + 8'd1;
        end
        4'd1: begin
          a1 = {s, off};
          exp_bus(1'b0, a1, 8'h0, t); exp_rsp(1'b0, ref_mem[a1[11:0]], t);
        end
        4'd2: begin
          exp_bus(1'b1, {s, off}, wd, t); exp_rsp(1'b0, 8'h0, t);
        end
        4'd3: begin
          m_sp = m_sp - 8'd1;
          exp_bus(1'b1, {s, m_sp}, wd, t); exp_rsp(1'b0, 8'h0, t);
        end
        4'd4: begin
          a1 = {s, m_sp};
          exp_bus(1'b0, a1, 8'h0, t); exp_rsp(1'b0, ref_mem[a1[11:0]], t);
          m_sp = m_sp + 8'd1;
        end
        4'd5: begin
          o1 = m_sp - 8'd1; o2 = m_sp - 8'd2;
          exp_bus(1'b1, {s, o1}, m_seg[rg[1:0]], t);
          exp_bus(1'b1, {s, o2}, wd, t);
          exp_rsp(1'b0, 8'h0, t);
          m_sp = o2;
        end
        4'd6: begin
          o2 = m_sp + 8'd1;
          a1 = {s, m_sp}; a2 = {s, o2};
          d1 = ref_mem[a1[11:0]]; d2 = ref_mem[a2[11:0]];
          exp_bus(1'b0, a1, 8'h0, t); exp_bus(1'b0, a2, 8'h0, t);
          exp_rsp(1'b0, d1, t);
          m_seg[rg[1:0]] = d2;
          m_sp = m_sp + 8'd2;
        end
        4'd7: begin
          o2 = off + 8'd1;
          a1 = {s, off}; a2 = {s, o2};
          exp_bus(1'b0, a1, 8'h0, t); exp_bus(1'b0, a2, 8'h0, t);
          exp_rsp(1'b0, 8'h0, t);
          m_seg[0] = ref_mem[a1[11:0]];
          m_ip = ref_mem[a2[11:0]];
        end
        default: begin
          if (rg < 3'd4) m_seg[rg[1:0]] = wd;
          else if (rg == 3'd4) m_sp = wd;
          else if (rg == 3'd5) m_ip = wd;
        end
      endcase
    end
    while (busy) @(negedge clk);
    req_op = op; req_reg = rg; req_xseg = xs; req_mem_operand = mo;
    req_offset = off; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_mem_operand = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 8'(i * 13 + 5);
      ref_mem[i] = 8'(i * 13 + 5);
    end
    for (int i = 0; i < 4; i++) m_seg[i] = 8'h0;
    m_sp = 8'h0; m_ip = 8'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    chk(busy == 1'b0, "R1", "busy after reset", {31'h0, busy}, 32'h0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", {31'h0, mem_req}, 32'h0);
    chk(rsp_valid == 1'b0 && rsp_illegal == 1'b0, "R1", "response after reset",
        {30'h0, rsp_valid, rsp_illegal}, 32'h0);
    // R1 R2: first fetch comes from address zero, extra-segment bit ignored
    run(4'd0, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00, "R1");
    run(4'd0, 3'd0, 1'b1, 1'b0, 8'h00, 8'h00, "R2");
    // R11: load every register
    run(4'd8, 3'd0, 1'b0, 1'b0, 8'h00, 8'h03, "R11");
    run(4'd8, 3'd1, 1'b0, 1'b0, 8'h00, 8'h05, "R11");
    run(4'd8, 3'd2, 1'b0, 1'b0, 8'h00, 8'h07, "R11");
    run(4'd8, 3'd3, 1'b0, 1'b0, 8'h00, 8'h09, "R11");
    run(4'd8, 3'd4, 1'b0, 1'b0, 8'h00, 8'h10, "R11");
    run(4'd8, 3'd5, 1'b0, 1'b0, 8'h00, 8'hFF, "R11");
    // R2: fetch at IP FF, then wrap to 00
    run(4'd0, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00, "R2");
    run(4'd0, 3'd0, 1'b1, 1'b0, 8'h00, 8'h00, "R2");
    // R3: data segment and its override
    run(4'd1, 3'd0, 1'b0, 1'b0, 8'h20, 8'h00, "R3");
    run(4'd1, 3'd0, 1'b1, 1'b0, 8'h20, 8'h00, "R3");
    run(4'd2, 3'd0, 1'b0, 1'b0, 8'h21, 8'hA5, "R3");
    run(4'd1, 3'd0, 1'b0, 1'b0, 8'h21, 8'h00, "R3");
    run(4'd2, 3'd0, 1'b1, 1'b0, 8'h21, 8'h5A, "R3");
    run(4'd1, 3'd0, 1'b1, 1'b0, 8'h21, 8'h00, "R3");
    // R4 R5: stack segment, override, LIFO order
    run(4'd3, 3'd0, 1'b0, 1'b0, 8'h00, 8'h11, "R4");
    run(4'd3, 3'd0, 1'b1, 1'b0, 8'h00, 8'h22, "R4");
    run(4'd4, 3'd0, 1'b1, 1'b0, 8'h00, 8'h00, "R5");
    run(4'd4, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00, "R5");
    // R4 R5: SP wrap at zero
    run(4'd8, 3'd4, 1'b0, 1'b0, 8'h00, 8'h00, "R11");
    run(4'd3, 3'd0, 1'b0, 1'b0, 8'h00, 8'h33, "R4");
    run(4'd4, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00, "R5");
    run(4'd3, 3'd0, 1'b0, 1'b0, 8'h00, 8'h34, "R4");
    run(4'd4, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00, "R5");
    // R6 R10: extended push; requests while busy are ignored
    run(4'd5, 3'd1, 1'b0, 1'b0, 8'h00, 8'h44, "R6");
    chk(busy == 1'b1, "R10", "busy during sequence", {31'h0, busy}, 32'h1);
    req_op = 4'd3; req_wdata = 8'hEE; req_valid = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R10", "busy on second transfer", {31'h0, busy}, 32'h1);
    @(negedge clk);
    req_valid = 1'b0;
    // R7: extended pop into ES, ES then used by an overridden load
    run(4'd6, 3'd2, 1'b0, 1'b0, 8'h00, 8'h00, "R7");
    run(4'd1, 3'd0, 1'b1, 1'b0, 8'h30, 8'h00, "R7");
    run(4'd4, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00, "R10");
    // R8: far jump across the offset wrap, then fetch from the new CS:IP
    run(4'd8, 3'd2, 1'b0, 1'b0, 8'h00, 8'h07, "R11");
    run(4'd2, 3'd0, 1'b0, 1'b0, 8'hFF, 8'h02, "R8");
    run(4'd2, 3'd0, 1'b0, 1'b0, 8'h00, 8'h40, "R8");
    run(4'd7, 3'd0, 1'b0, 1'b0, 8'hFF, 8'h00, "R8");
    run(4'd0, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00, "R8");
    run(4'd2, 3'd0, 1'b1, 1'b0, 8'h10, 8'h0A, "R8");
    run(4'd2, 3'd0, 1'b1, 1'b0, 8'h11, 8'h66, "R8");
    run(4'd7, 3'd0, 1'b1, 1'b0, 8'h10, 8'h00, "R8");
    run(4'd0, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00, "R8");
    // R9: refusals leave SP and IP alone, seen by the requests that follow
    run(4'd3, 3'd0, 1'b0, 1'b1, 8'h00, 8'h77, "R9");
    run(4'd4, 3'd0, 1'b0, 1'b1, 8'h00, 8'h00, "R9");
    run(4'd12, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00, "R9");
    run(4'd0, 3'd0, 1'b0, 1'b1, 8'h00, 8'h00, "R9");
    run(4'd3, 3'd0, 1'b0, 1'b0, 8'h00, 8'h78, "R9");
    run(4'd0, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00, "R9");
    // R12: back-to-back single transfers
    run(4'd1, 3'd0, 1'b0, 1'b0, 8'h05, 8'h00, "R12");
    run(4'd1, 3'd0, 1'b0, 1'b0, 8'h06, 8'h00, "R12");
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_bus_q.size() == 0, "R12", "transfers left unseen", exp_bus_q.size(), 0);
    chk(exp_rsp_q.size() == 0, "R12", "responses left unseen", exp_rsp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

endmodule